// File: doc/BRIEF.md
# Single-Wire Link Slave Interface

This block is the downstream end of a half-duplex, open-drain, single-wire link. The wire is pulled up outside the chip. The block never drives it high. It either pulls the wire low or lets it float. An upstream master opens every session with a long low pulse. The slave waits briefly after the master lets go, then answers with a presence pulse of its own. Only after that exchange does the slave move data bits, and each bit occupies a fixed-length slot of about 100 µs. Long slots let a loosely trimmed clock on either side keep up.

Inside a slot the master always makes the first falling edge. In a write slot the master sets the bit value by how long it holds the wire low. In a read slot the slave holds the wire low afterwards to send a zero, or leaves it released to send a one. The packet layer receives each assembled byte through a one-cycle valid pulse. It offers bytes for sending with a valid/ready handshake. A fault flag reports a broken or stuck link: the wire stays high too long without any traffic, or stays low far beyond a reset length. All durations are given in microseconds and scaled by a clock-cycles-per-microsecond parameter. The wire input passes through a two-flop synchroniser.

Top module: `swl_slave`

## Requirements
- R1: The block only ever pulls the wire low (`drive_low_o`=1) or releases it. It is released after reset, and while linked it pulls low only during a byte accepted for sending.
- R2: A synchronised low period of at least RESET_MIN_US (400 µs) but shorter than twice RESET_NOM_US (1000 µs) counts as a master reset when the wire rises. A shorter low while unlinked produces no presence pulse and no link.
- R3: After a reset is released, the block waits PRES_WAIT_US (30 µs) and then pulls low for PRES_US (100 µs). `linked_o` rises in the same cycle that this presence pulse ends.
- R4: While `linked_o` is 0, `rx_valid_o` and `tx_ready_o` stay 0.
- R5: In a write slot, a low shorter than ONE_MAX_US (30 µs) is a 1 and a low longer than ZERO_MIN_US (60 µs) is a 0. Bits arrive LSB first. After the eighth bit, `rx_data_o` holds the byte and `rx_valid_o` pulses.
- R6: A write-slot low between ONE_MAX_US and ZERO_MIN_US is discarded. It adds no bit, and the byte continues with the next slot.
- R7: `tx_ready_o` is 1 when linked with no byte pending. A byte is taken when valid and ready are both 1, and `tx_ready_o` then drops. The next eight slots send it LSB first. For a 0 the block holds the wire low for TX_HOLD_US (75 µs) after it sees the master's falling edge. For a 1 it leaves the wire released.
- R8: A low lasting STUCK (2×RESET_NOM_US) raises `fault_o` and clears `linked_o`. The rise that follows is not taken as a reset.
- R9: A wire that stays high for TIMEOUT_US raises `fault_o` and clears `linked_o`.
- R10: A valid reset clears `fault_o` and restarts the handshake. A reset that arrives partway through a byte throws the partial bits away.
- R11: `rx_valid_o` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Wire level as seen at the pad |
| drive_low_o | output | 1 | 1 = pull the wire low, 0 = release |
| linked_o | output | 1 | Reset/presence handshake complete |
| fault_o | output | 1 | Link break or stuck-low detected |
| rx_data_o | output | DATA_W | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe for rx_data_o |
| tx_data_i | input | DATA_W | Byte offered for sending |
| tx_valid_i | input | 1 | Byte offer strobe |
| tx_ready_o | output | 1 | Block can take a byte |

## Verification
Some rules are checked on every cycle. The handshake strobes stay silent until the link is up. A fault and an active link never exist together. The end of the presence pulse is exactly the moment the link comes up. While linked, the wire is pulled low only when a byte is pending. The receive strobe never lasts two cycles. Other behaviour can only be shown by the bench's scenarios: the split between reset length and data lows, the discarding of mid-length lows, bit order in both directions, a partial byte abandoned by a reset, and fault detection at both the stuck-low and idle-high limits.

// File: rtl/swl_pkg.sv
package swl_pkg;

    typedef enum logic [1:0] {
        LS_IDLE       = 2'd0,
        LS_PRES_WAIT  = 2'd1,
        LS_PRES_DRIVE = 2'd2,
        LS_READY      = 2'd3
    } link_state_e;

endpackage

// File: rtl/swl_sync.sv
module swl_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic level_o,
    output logic fall_o,
    output logic rise_o
);

    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d      = sync_q;
        sync_d.s1   = raw_i;
        sync_d.s2   = sync_q.s1;
        sync_d.prev = sync_q.s2;
    end

    // idle wire is high: reset every stage to 1 so no edge appears at start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign level_o = sync_q.s2;
    assign fall_o  = sync_q.prev & ~sync_q.s2;
    assign rise_o  = ~sync_q.prev & sync_q.s2;

endmodule

// File: rtl/swl_span_timer.sv
module swl_span_timer #(
    parameter int CNT_W     = 16,
    parameter int STUCK_CYC = 8000,
    parameter int IDLE_CYC  = 40000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             level_i,
    output logic [CNT_W-1:0] low_len_o,
    output logic             stuck_o,
    output logic             idle_o
);

    localparam logic [CNT_W-1:0] STUCK_L = CNT_W'(STUCK_CYC);
    localparam logic [CNT_W-1:0] IDLE_L  = CNT_W'(IDLE_CYC);

    typedef struct packed {
        logic [CNT_W-1:0] low;
        logic [CNT_W-1:0] high;
    } span_t;

    span_t span_d, span_q;

    always_comb begin
        span_d = span_q;
        if (level_i) begin
            span_d.low = '0;
            if (span_q.high != IDLE_L) span_d.high = span_q.high + 1'b1;
        end else begin
            span_d.high = '0;
            if (span_q.low != STUCK_L) span_d.low = span_q.low + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) span_q <= '0;
        else        span_q <= span_d;
    end

    // on the rise cycle low still holds the full low length
    assign low_len_o = span_q.low;
    assign stuck_o   = (span_q.low == STUCK_L);
    assign idle_o    = (span_q.high == IDLE_L);

endmodule

// File: rtl/swl_slot_fsm.sv
module swl_slot_fsm
    import swl_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int CNT_W         = 16,
    parameter int TMR_W         = 10,
    parameter int RESET_MIN_CYC = 3200,
    parameter int STUCK_CYC     = 8000,
    parameter int ONE_MAX_CYC   = 240,
    parameter int ZERO_MIN_CYC  = 480,
    parameter int PRES_WAIT_CYC = 240,
    parameter int PRES_CYC      = 800,
    parameter int TX_HOLD_CYC   = 600
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall_i,
    input  logic              rise_i,
    input  logic [CNT_W-1:0]  low_len_i,
    input  logic              stuck_i,
    input  logic              idle_i,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              tx_valid_i,
    output logic              tx_ready_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_valid_o,
    output logic              drive_low_o,
    output logic              linked_o,
    output logic              fault_o
);

    localparam int BC_W = $clog2(DATA_W + 1);

    localparam logic [CNT_W-1:0] RST_MIN_L  = CNT_W'(RESET_MIN_CYC);
    localparam logic [CNT_W-1:0] STUCK_L    = CNT_W'(STUCK_CYC);
    localparam logic [CNT_W-1:0] ONE_MAX_L  = CNT_W'(ONE_MAX_CYC);
    localparam logic [CNT_W-1:0] ZERO_MIN_L = CNT_W'(ZERO_MIN_CYC);
    localparam logic [TMR_W-1:0] PW_LAST    = TMR_W'(PRES_WAIT_CYC - 1);
    localparam logic [TMR_W-1:0] PD_LAST    = TMR_W'(PRES_CYC - 1);
    localparam logic [TMR_W-1:0] TH_LAST    = TMR_W'(TX_HOLD_CYC - 1);
    localparam logic [BC_W-1:0]  BIT_LAST   = BC_W'(DATA_W - 1);

    typedef struct packed {
        link_state_e       st;
        logic [TMR_W-1:0]  tmr;
        logic              slot_act;
        logic              slot_tx;
        logic [DATA_W-1:0] rx_sh;
        logic [BC_W-1:0]   rx_cnt;
        logic              rx_vld;
        logic [DATA_W-1:0] rx_out;
        logic [DATA_W-1:0] tx_sh;
        logic [BC_W-1:0]   tx_cnt;
        logic              tx_busy;
        logic              drive;
        logic              fault;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    logic              valid_reset;
    logic              bit_ok;
    logic              bit_val;
    logic [DATA_W-1:0] rx_next;

    assign valid_reset = rise_i && (low_len_i >= RST_MIN_L) && (low_len_i < STUCK_L);

    // classify a completed write-slot low by its length
    always_comb begin
        bit_ok  = 1'b0;
        bit_val = 1'b0;
        if (low_len_i < ONE_MAX_L) begin
            bit_ok  = 1'b1;
            bit_val = 1'b1;
        end else if (low_len_i > ZERO_MIN_L) begin
            bit_ok  = 1'b1;
            bit_val = 1'b0;
        end
        rx_next = {bit_val, fsm_q.rx_sh[DATA_W-1:1]};
    end

    assign tx_ready_o = (fsm_q.st == LS_READY) && !fsm_q.tx_busy && !fsm_q.slot_act;

    always_comb begin
        fsm_d        = fsm_q;
        fsm_d.rx_vld = 1'b0;

        case (fsm_q.st)
            LS_IDLE: begin
                fsm_d.drive = 1'b0;
                if (valid_reset) begin
                    fsm_d.st    = LS_PRES_WAIT;
                    fsm_d.tmr   = '0;
                    fsm_d.fault = 1'b0;
                end
            end

            LS_PRES_WAIT: begin
                if (fsm_q.tmr == PW_LAST) begin
                    fsm_d.tmr   = '0;
                    fsm_d.st    = LS_PRES_DRIVE;
                    fsm_d.drive = 1'b1;
                end else begin
                    fsm_d.tmr = fsm_q.tmr + 1'b1;
                end
            end

            LS_PRES_DRIVE: begin
                if (fsm_q.tmr == PD_LAST) begin
                    fsm_d.tmr      = '0;
                    fsm_d.drive    = 1'b0;
                    fsm_d.st       = LS_READY;
                    fsm_d.slot_act = 1'b0;
                    fsm_d.slot_tx  = 1'b0;
                    fsm_d.rx_cnt   = '0;
                    fsm_d.tx_cnt   = '0;
                    fsm_d.tx_busy  = 1'b0;
                end else begin
                    fsm_d.tmr = fsm_q.tmr + 1'b1;
                end
            end

            LS_READY: begin
                if (valid_reset) begin
                    // restart handshake, drop any partial byte either way
                    fsm_d.st       = LS_PRES_WAIT;
                    fsm_d.tmr      = '0;
                    fsm_d.fault    = 1'b0;
                    fsm_d.slot_act = 1'b0;
                    fsm_d.rx_cnt   = '0;
                    fsm_d.tx_busy  = 1'b0;
                    fsm_d.drive    = 1'b0;
                end else begin
                    if (tx_valid_i && tx_ready_o) begin
                        fsm_d.tx_sh   = tx_data_i;
                        fsm_d.tx_cnt  = '0;
                        fsm_d.tx_busy = 1'b1;
                    end

                    if (fsm_q.drive) begin
                        if (fsm_q.tmr == TH_LAST) fsm_d.drive = 1'b0;
                        else                      fsm_d.tmr   = fsm_q.tmr + 1'b1;
                    end

                    if (fall_i) begin
                        fsm_d.slot_act = 1'b1;
                        fsm_d.slot_tx  = fsm_q.tx_busy;
                        if (fsm_q.tx_busy && !fsm_q.tx_sh[0]) begin
                            fsm_d.drive = 1'b1;
                            fsm_d.tmr   = '0;
                        end
                    end else if (rise_i && fsm_q.slot_act) begin
                        fsm_d.slot_act = 1'b0;
                        if (fsm_q.slot_tx) begin
                            fsm_d.tx_sh  = fsm_q.tx_sh >> 1;
                            fsm_d.tx_cnt = fsm_q.tx_cnt + 1'b1;
                            if (fsm_q.tx_cnt == BIT_LAST) begin
                                fsm_d.tx_busy = 1'b0;
                                fsm_d.tx_cnt  = '0;
                            end
                        end else if (bit_ok) begin
                            fsm_d.rx_sh = rx_next;
                            if (fsm_q.rx_cnt == BIT_LAST) begin
                                fsm_d.rx_cnt = '0;
                                fsm_d.rx_out = rx_next;
                                fsm_d.rx_vld = 1'b1;
                            end else begin
                                fsm_d.rx_cnt = fsm_q.rx_cnt + 1'b1;
                            end
                        end
                    end
                end
            end

            default: fsm_d.st = LS_IDLE;
        endcase

        // wire broken or stuck: drop the link whatever was in progress
        if (stuck_i || idle_i) begin
            fsm_d.fault    = 1'b1;
            fsm_d.st       = LS_IDLE;
            fsm_d.drive    = 1'b0;
            fsm_d.tx_busy  = 1'b0;
            fsm_d.slot_act = 1'b0;
            fsm_d.rx_cnt   = '0;
            fsm_d.rx_vld   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q    <= '0;
            fsm_q.st <= LS_IDLE;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign rx_data_o   = fsm_q.rx_out;
    assign rx_valid_o  = fsm_q.rx_vld;
    assign drive_low_o = fsm_q.drive;
    assign linked_o    = (fsm_q.st == LS_READY);
    assign fault_o     = fsm_q.fault;

endmodule

// File: rtl/swl_slave.sv
module swl_slave #(
    parameter int DATA_W       = 8,
    parameter int CLK_PER_US   = 8,
    parameter int RESET_MIN_US = 400,
    parameter int RESET_NOM_US = 500,
    parameter int ONE_MAX_US   = 30,
    parameter int ZERO_MIN_US  = 60,
    parameter int PRES_WAIT_US = 30,
    parameter int PRES_US      = 100,
    parameter int TX_HOLD_US   = 75,
    parameter int TIMEOUT_US   = 5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_i,
    output logic              drive_low_o,
    output logic              linked_o,
    output logic              fault_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_valid_o,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              tx_valid_i,
    output logic              tx_ready_o
);

    localparam int RESET_MIN_CYC = RESET_MIN_US * CLK_PER_US;
    localparam int STUCK_CYC     = 2 * RESET_NOM_US * CLK_PER_US;
    localparam int IDLE_CYC      = TIMEOUT_US * CLK_PER_US;
    localparam int ONE_MAX_CYC   = ONE_MAX_US * CLK_PER_US;
    localparam int ZERO_MIN_CYC  = ZERO_MIN_US * CLK_PER_US;
    localparam int PRES_WAIT_CYC = PRES_WAIT_US * CLK_PER_US;
    localparam int PRES_CYC      = PRES_US * CLK_PER_US;
    localparam int TX_HOLD_CYC   = TX_HOLD_US * CLK_PER_US;
    localparam int SPAN_MAX      = (STUCK_CYC > IDLE_CYC) ? STUCK_CYC : IDLE_CYC;
    localparam int CNT_W         = $clog2(SPAN_MAX + 1);
    localparam int TMR_MAX0      = (PRES_WAIT_CYC > PRES_CYC) ? PRES_WAIT_CYC : PRES_CYC;
    localparam int TMR_MAX       = (TMR_MAX0 > TX_HOLD_CYC) ? TMR_MAX0 : TX_HOLD_CYC;
    localparam int TMR_W         = $clog2(TMR_MAX + 1);

    logic             level_s;
    logic             fall_s;
    logic             rise_s;
    logic [CNT_W-1:0] low_len;
    logic             stuck;
    logic             idle;

    swl_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_i   (line_i),
        .level_o (level_s),
        .fall_o  (fall_s),
        .rise_o  (rise_s)
    );

    swl_span_timer #(
        .CNT_W     (CNT_W),
        .STUCK_CYC (STUCK_CYC),
        .IDLE_CYC  (IDLE_CYC)
    ) u_span (
        .clk       (clk),
        .rst_n     (rst_n),
        .level_i   (level_s),
        .low_len_o (low_len),
        .stuck_o   (stuck),
        .idle_o    (idle)
    );

    swl_slot_fsm #(
        .DATA_W        (DATA_W),
        .CNT_W         (CNT_W),
        .TMR_W         (TMR_W),
        .RESET_MIN_CYC (RESET_MIN_CYC),
        .STUCK_CYC     (STUCK_CYC),
        .ONE_MAX_CYC   (ONE_MAX_CYC),
        .ZERO_MIN_CYC  (ZERO_MIN_CYC),
        .PRES_WAIT_CYC (PRES_WAIT_CYC),
        .PRES_CYC      (PRES_CYC),
        .TX_HOLD_CYC   (TX_HOLD_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .fall_i      (fall_s),
        .rise_i      (rise_s),
        .low_len_i   (low_len),
        .stuck_i     (stuck),
        .idle_i      (idle),
        .tx_data_i   (tx_data_i),
        .tx_valid_i  (tx_valid_i),
        .tx_ready_o  (tx_ready_o),
        .rx_data_o   (rx_data_o),
        .rx_valid_o  (rx_valid_o),
        .drive_low_o (drive_low_o),
        .linked_o    (linked_o),
        .fault_o     (fault_o)
    );

endmodule

// File: rtl/swl_slave_chk.sv
module swl_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic drive_low_o,
    input logic linked_o,
    input logic fault_o,
    input logic rx_valid_o,
    input logic tx_ready_o
);

    // R1: while linked the wire is pulled low only for a pending byte
    p_drive_only_tx_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_low_o && linked_o) |-> !tx_ready_o)
        else $error("p_drive_only_tx_r1");

    // R3: link comes up exactly as the presence pulse ends
    p_presence_to_link_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(linked_o) |-> $fell(drive_low_o))
        else $error("p_presence_to_link_r3");

    // R4: handshake strobes silent while unlinked
    p_rx_needs_link_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> linked_o)
        else $error("p_rx_needs_link_r4");

    p_tx_needs_link_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready_o |-> linked_o)
        else $error("p_tx_needs_link_r4");

    // R8: a fault and a live link never coexist, and a faulted block releases the wire
    p_fault_unlinks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (!linked_o && !drive_low_o))
        else $error("p_fault_unlinks_r8");

    // R11: receive strobe lasts one cycle
    p_rx_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o)
        else $error("p_rx_pulse_r11");

endmodule

bind swl_slave swl_slave_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .drive_low_o (drive_low_o),
    .linked_o    (linked_o),
    .fault_o     (fault_o),
    .rx_valid_o  (rx_valid_o),
    .tx_ready_o  (tx_ready_o)
);

// File: tb/swl_slave_test.sv
module swl_slave_test;

    localparam int CLK_PERIOD = 10;
    localparam int CPU        = 2;
    localparam int TMO_US     = 3000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_low = 1'b0;
    logic       line_w;
    logic       drive_low;
    logic       linked;
    logic       fault;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0;
    logic       tx_ready;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    // open-drain wire with pull-up
    assign line_w = ~(m_low | drive_low);

    swl_slave #(.CLK_PER_US(CPU), .TIMEOUT_US(TMO_US)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_i      (line_w),
        .drive_low_o (drive_low),
        .linked_o    (linked),
        .fault_o     (fault),
        .rx_data_o   (rx_data),
        .rx_valid_o  (rx_valid),
        .tx_data_i   (tx_data),
        .tx_valid_i  (tx_valid),
        .tx_ready_o  (tx_ready)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_us(input int n);
        repeat (n * CPU) @(negedge clk);
    endtask

    task automatic master_low(input int us);
        m_low = 1'b1;
        wait_us(us);
        m_low = 1'b0;
    endtask

    task automatic handshake(input string tag);
        master_low(500);
        wait_us(10);
        check(drive_low == 1'b0, {tag, " R3 no drive during wait"}, drive_low, 0);
        wait_us(50);
        check(drive_low == 1'b1, {tag, " R3 presence driven"}, drive_low, 1);
        wait_us(80);
        check(drive_low == 1'b0, {tag, " R3 presence ended"}, drive_low, 0);
        check(linked == 1'b1, {tag, " R2 R3 linked"}, linked, 1);
        wait_us(10);
    endtask

    task automatic write_bit(input logic b);
        if (b) begin master_low(10); wait_us(90); end
        else   begin master_low(80); wait_us(20); end
        wait_us(10);
    endtask

    task automatic write_byte(input logic [7:0] v);
        exp_q.push_back(v);
        for (int i = 0; i < 8; i++) write_bit(v[i]);
    endtask

    task automatic read_bit(output logic b);
        master_low(5);
        wait_us(40);
        b = line_w;
        wait_us(65);
    endtask

    task automatic read_byte(input logic [7:0] exp);
        logic [7:0] got;
        logic       b;
        check(tx_ready == 1'b1, "R7 ready before offer", tx_ready, 1);
        tx_data  = exp;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        check(tx_ready == 1'b0, "R7 ready drops after accept", tx_ready, 0);
        for (int i = 0; i < 8; i++) begin
            read_bit(b);
            got[i] = b;
        end
        check(got == exp, "R7 byte read from slave", got, exp);
        check(tx_ready == 1'b1, "R7 ready after byte", tx_ready, 1);
    endtask

    // scoreboard monitor for received bytes (R5, R6, R10, R11)
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10 unexpected rx byte", rx_data, 0);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                check(rx_data == e, "R5 rx byte", rx_data, e);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic b;
        repeat (5) @(negedge clk);
        check(drive_low == 1'b0, "R1 released after reset", drive_low, 0);
        check(linked == 1'b0, "R4 unlinked after reset", linked, 0);
        check(tx_ready == 1'b0, "R4 tx_ready low unlinked", tx_ready, 0);
        check(fault == 1'b0, "R9 no fault after reset", fault, 0);
        rst_n = 1'b1;
        wait_us(20);

        // short low while unlinked: ignored
        master_low(200);
        wait_us(60);
        check(drive_low == 1'b0, "R2 short low gives no presence", drive_low, 0);
        check(linked == 1'b0, "R2 short low gives no link", linked, 0);
        wait_us(100);

        handshake("first");

        // plain receive
        write_byte(8'hA5);
        write_byte(8'h3C);

        // mid-length low inserted after bit 3
        begin
            logic [7:0] v = 8'h5A;
            exp_q.push_back(v);
            for (int i = 0; i < 4; i++) write_bit(v[i]);
            master_low(45); wait_us(55); wait_us(10);   // R6 discarded slot
            for (int i = 4; i < 8; i++) write_bit(v[i]);
        end
        check(exp_q.size() == 0, "R6 byte complete with discarded slot", exp_q.size(), 0);

        // transmit
        read_byte(8'h96);
        read_byte(8'h01);

        // partial byte then reset
        write_bit(1'b0); write_bit(1'b1); write_bit(1'b1);
        handshake("mid-byte");
        write_byte(8'hC3);
        check(exp_q.size() == 0, "R10 only post-reset byte received", exp_q.size(), 0);

        // stuck low
        m_low = 1'b1;
        wait_us(1050);
        check(fault == 1'b1, "R8 fault on stuck low", fault, 1);
        check(linked == 1'b0, "R8 link dropped", linked, 0);
        wait_us(50);
        m_low = 1'b0;
        wait_us(60);
        check(drive_low == 1'b0, "R8 no presence after stuck low", drive_low, 0);
        check(fault == 1'b1, "R8 fault held", fault, 1);

        handshake("recover");
        check(fault == 1'b0, "R10 fault cleared by reset", fault, 0);
        write_byte(8'h0F);
        check(exp_q.size() == 0, "R5 byte after recovery", exp_q.size(), 0);

        // idle high timeout
        wait_us(TMO_US + 100);
        check(fault == 1'b1, "R9 fault on idle wire", fault, 1);
        check(linked == 1'b0, "R9 link dropped on idle", linked, 0);
        read_bit(b);
        check(b == 1'b1, "R1 wire released while faulted", b, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule